// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block runs program and erase jobs against a serial NOR flash from the host side. A job is handed over on a valid/ready handshake. It is one of three kinds: program a run of bytes starting at an address, erase the sector that holds an address, or erase the whole array. The block is the SPI mode 0 master, so the serial clock idles low, the master changes data while the clock is low, and the flash samples on the rising edge. It builds every chip-select frame itself.

Each modifying command goes through the same steps. First comes a write-enable frame. Next, a status-read frame confirms that the write-enable latch is set. Then the command frame goes out, and a status-read frame keeps polling until the write-in-progress bit clears. A program job is cut at 256-byte page boundaries, and each piece runs through the full sequence. Program data is pulled byte by byte from a simple fetch port with a fixed latency of one cycle.

When the job finishes, a one-cycle done pulse is raised. An error flag goes with it if the latch check or the poll timeout failed.

Top module: `flash_pe_seq`

## Requirements
- R1: `req_ready` is high only while the block is idle. A request is accepted when `req_valid` and `req_ready` are both high, and `req_ready` then stays low until after `done`.
- R2: The serial link runs in SPI mode 0. `spi_sclk` is low whenever `spi_cs_n` changes and is never high while `spi_cs_n` is high. Bytes go out most significant bit first, and one bit period is 2*CLK_HALF clock cycles.
- R3: Every modifying command is preceded by two frames. The first is a write-enable frame holding the single byte 0x06. The second is a check frame holding 0x05 followed by one 0x00 byte, whose returned status must have bit 1 set. If bit 1 reads 0, no command frame is sent, and the job ends with `done` and `err` both high.
- R4: A program frame is 0x02, then the address as three bytes (high byte 0x00, then address bits 15:8, then bits 7:0), then the data bytes. Each data byte is requested by a `rd_req` pulse with its address on `rd_addr`. The byte is taken from `rd_data` in the following cycle.
- R5: A program request with start address A and count N (`req_len` = N-1) is split into pieces that never cross a 256-byte page boundary. Each piece gets its own write-enable, check, program and poll frames, in address order.
- R6: `req_op` 2'b01 sends a sector erase frame: 0xD8 followed by the three address bytes of `req_addr`. `req_op` 2'b10 or 2'b11 sends a bulk erase frame, which is the single byte 0xC7, and ignores the address. `req_op` 2'b00 is a program job.
- R7: After each command frame comes a poll frame: 0x05, then 0x00 bytes while status is read back. The frame ends right after the first status byte whose bit 0 is 0.
- R8: If POLL_LIMIT status bytes in a row show bit 0 high, the poll frame ends after the last of them. The job then ends with `done` and `err` both high, and the remaining program pieces are dropped.
- R9: Every frame holds a whole number of bytes, and `spi_cs_n` rises right after the last bit. Between frames, `spi_cs_n` stays high for at least 2*CLK_HALF clock cycles.
- R10: `done` is a single-cycle pulse. `err` is high only in the cycle where `done` is high.
- R11: After reset, `spi_cs_n` is high, `spi_sclk` is low, `req_ready` is high, and `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_op | input | 2 | 00 program, 01 sector erase, 1x bulk erase |
| req_addr | input | ADDR_W | Start address (program) or any address inside the sector |
| req_len | input | LEN_W | Program byte count minus one |
| rd_req | output | 1 | Fetch strobe for one program data byte |
| rd_addr | output | ADDR_W | Address of the byte being fetched |
| rd_data | input | 8 | Fetched byte, valid the cycle after rd_req |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| done | output | 1 | Job-complete pulse |
| err | output | 1 | Job failed, valid with done |

## Verification
The bench builds the block with CLK_HALF = 2, so one byte takes about 33 cycles and a full 256-byte page fits easily in the run. POLL_LIMIT is set to 8, which keeps the timeout path short: a flash model held busy for 50 reads trips it. A busy count of 7 probes the last read that still succeeds. The page size stays at its default of 256, so the bench can drive a page-crossing program, a write that fills a whole page, and a crossing at a 4 KB address.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  localparam logic [7:0] OPC_WR_EN   = 8'h06;
  localparam logic [7:0] OPC_STATUS  = 8'h05;
  localparam logic [7:0] OPC_PROGRAM = 8'h02;
  localparam logic [7:0] OPC_SECTOR  = 8'hD8;
  localparam logic [7:0] OPC_CHIP    = 8'hC7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WREN,
    ST_WCHK,
    ST_CMD,
    ST_POLL,
    ST_GAP,
    ST_FIN
  } seq_state_e;

endpackage

// File: rtl/fseq_spi_shifter.sv
module fseq_spi_shifter #(
  parameter int CLK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  output logic       active,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);
  localparam int DIV_W = $clog2(CLK_HALF) + 1;
  localparam logic [DIV_W-1:0] DIV_END = DIV_W'(CLK_HALF - 1);

  logic             act_q, act_d;
  logic             sclk_q, sclk_d;
  logic             done_q, done_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d;
  logic [7:0]       rx_q, rx_d;

  always_comb begin
    act_d  = act_q;
    sclk_d = sclk_q;
    done_d = 1'b0;
    div_d  = div_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    rx_d   = rx_q;
    if (!act_q) begin
      if (start) begin
        act_d  = 1'b1;
        sh_d   = tx_byte;
        bit_d  = '0;
        div_d  = '0;
        sclk_d = 1'b0;
      end
    end else if (div_q == DIV_END) begin
      div_d = '0;
      if (!sclk_q) begin
        sclk_d = 1'b1;
        rx_d   = {rx_q[6:0], miso};
      end else begin
        sclk_d = 1'b0;
        if (bit_q == 3'd7) begin
          act_d  = 1'b0;
          done_d = 1'b1;
        end else begin
          bit_d = bit_q + 3'd1;
          sh_d  = {sh_q[6:0], 1'b0};
        end
      end
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
    end else begin
      act_q  <= act_d;
      sclk_q <= sclk_d;
      done_q <= done_d;
      div_q  <= div_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      rx_q   <= rx_d;
    end
  end

  assign active  = act_q;
  assign done    = done_q;
  assign rx_byte = rx_q;
  assign sclk    = sclk_q;
  assign mosi    = sh_q[7];
endmodule

// File: rtl/fseq_chunker.sv
module fseq_chunker #(
  parameter int PAGE_BYTES = 256,
  parameter int REM_W      = 17,
  localparam int PG_W      = $clog2(PAGE_BYTES),
  localparam int CNT_W     = PG_W + 1
) (
  input  logic [PG_W-1:0]  page_off,
  input  logic [REM_W-1:0] remaining,
  output logic [CNT_W-1:0] chunk
);
  logic [CNT_W-1:0] to_end;

  always_comb begin
    to_end = CNT_W'(PAGE_BYTES) - {1'b0, page_off};
    if (REM_W'(to_end) > remaining) chunk = CNT_W'(remaining);
    else                            chunk = to_end;
  end
endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
  import fseq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 256,
  parameter int CLK_HALF   = 2,
  parameter int POLL_LIMIT = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              done,
  output logic              err
);
  localparam int REM_W   = LEN_W + 1;
  localparam int PG_W    = $clog2(PAGE_BYTES);
  localparam int CNT_W   = PG_W + 1;
  localparam int GAP_CYC = 2 * CLK_HALF;
  localparam int GAP_W   = $clog2(GAP_CYC) + 1;
  localparam int POLL_W  = $clog2(POLL_LIMIT) + 1;

  seq_state_e        state_q, state_d, ret_q, ret_d;
  logic [1:0]        op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [REM_W-1:0]  rem_q, rem_d;
  logic [CNT_W-1:0]  chunk_q, chunk_d, chunk_calc;
  logic [2:0]        bidx_q, bidx_d;
  logic [GAP_W-1:0]  gap_q, gap_d;
  logic [POLL_W-1:0] poll_q, poll_d;
  logic              err_q, err_d;

  logic       eng_start, eng_active, eng_done;
  logic [7:0] eng_tx, eng_rx;
  logic       xfer_st, is_prog, is_sect;
  logic [23:0] addr24;
  logic       unused_status;

  assign xfer_st = (state_q == ST_WREN) || (state_q == ST_WCHK) ||
                   (state_q == ST_CMD)  || (state_q == ST_POLL);
  assign is_prog = (op_q == 2'b00);
  assign is_sect = (op_q == 2'b01);
  assign addr24  = 24'(addr_q);
  assign eng_start = xfer_st && !eng_active && !eng_done;
  assign unused_status = ^eng_rx[7:2];

  fseq_spi_shifter #(.CLK_HALF(CLK_HALF)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (eng_start),
    .tx_byte (eng_tx),
    .active  (eng_active),
    .done    (eng_done),
    .rx_byte (eng_rx),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi),
    .miso    (spi_miso)
  );

  fseq_chunker #(.PAGE_BYTES(PAGE_BYTES), .REM_W(REM_W)) u_chunk (
    .page_off  (addr_q[PG_W-1:0]),
    .remaining (rem_q),
    .chunk     (chunk_calc)
  );

  // Byte to shift out, chosen by frame kind and position in the frame
  always_comb begin
    eng_tx = 8'h00;
    case (state_q)
      ST_WREN: eng_tx = OPC_WR_EN;
      ST_WCHK, ST_POLL: eng_tx = (bidx_q == 3'd0) ? OPC_STATUS : 8'h00;
      ST_CMD: begin
        case (bidx_q)
          3'd0: eng_tx = op_q[1] ? OPC_CHIP : (is_sect ? OPC_SECTOR : OPC_PROGRAM);
          3'd1: eng_tx = addr24[23:16];
          3'd2: eng_tx = addr24[15:8];
          3'd3: eng_tx = addr24[7:0];
          default: eng_tx = rd_data;
        endcase
      end
      default: eng_tx = 8'h00;
    endcase
  end

  always_comb begin
    state_d = state_q;
    ret_d   = ret_q;
    op_d    = op_q;
    addr_d  = addr_q;
    rem_d   = rem_q;
    chunk_d = chunk_q;
    bidx_d  = bidx_q;
    gap_d   = gap_q;
    poll_d  = poll_q;
    err_d   = err_q;

    if (state_q == ST_CMD && eng_start && bidx_q == 3'd4) begin
      addr_d  = addr_q + 1'b1;
      rem_d   = rem_q - 1'b1;
      chunk_d = chunk_q - 1'b1;
    end

    case (state_q)
      ST_IDLE: if (req_valid) begin
        op_d    = req_op;
        addr_d  = req_addr;
        rem_d   = REM_W'(req_len) + 1'b1;
        err_d   = 1'b0;
        state_d = ST_WREN;
      end
      ST_WREN: if (eng_done) begin
        state_d = ST_GAP;
        ret_d   = ST_WCHK;
      end
      ST_WCHK: if (eng_done) begin
        if (bidx_q == 3'd0) bidx_d = 3'd1;
        else begin
          bidx_d  = 3'd0;
          state_d = ST_GAP;
          if (eng_rx[1]) begin
            ret_d   = ST_CMD;
            chunk_d = chunk_calc;
          end else begin
            ret_d = ST_FIN;
            err_d = 1'b1;
          end
        end
      end
      ST_CMD: if (eng_done) begin
        if (op_q[1] || (is_sect && bidx_q == 3'd3) ||
            (bidx_q == 3'd4 && chunk_q == '0)) begin
          bidx_d  = 3'd0;
          state_d = ST_GAP;
          ret_d   = ST_POLL;
        end else if (bidx_q != 3'd4) begin
          bidx_d = bidx_q + 3'd1;
        end
      end
      ST_POLL: if (eng_done) begin
        if (bidx_q == 3'd0) begin
          bidx_d = 3'd1;
          poll_d = '0;
        end else if (!eng_rx[0]) begin
          bidx_d  = 3'd0;
          state_d = ST_GAP;
          ret_d   = (is_prog && rem_q != '0) ? ST_WREN : ST_FIN;
        end else if (poll_q == POLL_W'(POLL_LIMIT - 1)) begin
          bidx_d  = 3'd0;
          state_d = ST_GAP;
          ret_d   = ST_FIN;
          err_d   = 1'b1;
        end else begin
          poll_d = poll_q + 1'b1;
        end
      end
      ST_GAP: begin
        if (gap_q == GAP_W'(GAP_CYC - 1)) begin
          gap_d   = '0;
          state_d = ret_q;
        end else begin
          gap_d = gap_q + 1'b1;
        end
      end
      ST_FIN: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ret_q   <= ST_IDLE;
      op_q    <= '0;
      addr_q  <= '0;
      rem_q   <= '0;
      chunk_q <= '0;
      bidx_q  <= '0;
      gap_q   <= '0;
      poll_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
      op_q    <= op_d;
      addr_q  <= addr_d;
      rem_q   <= rem_d;
      chunk_q <= chunk_d;
      bidx_q  <= bidx_d;
      gap_q   <= gap_d;
      poll_q  <= poll_d;
      err_q   <= err_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign done      = (state_q == ST_FIN);
  assign err       = done && err_q;
  assign spi_cs_n  = !xfer_st;
  assign rd_req    = eng_done && (state_q == ST_CMD) && is_prog &&
                     (bidx_q >= 3'd3) && (chunk_q != '0);
  assign rd_addr   = addr_q;
endmodule

// File: rtl/fseq_checker.sv
module fseq_checker (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic done,
  input logic err,
  input logic spi_cs_n,
  input logic spi_sclk,
  input logic rd_req
);
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R1
  AST_NOT_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready); // R1
  AST_SCLK_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> !spi_cs_n); // R2
  AST_CS_EDGE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(spi_cs_n) || $fell(spi_cs_n)) |-> !spi_sclk); // R2
  AST_FETCH_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !spi_cs_n); // R4
  AST_GAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |=> spi_cs_n); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done); // R10
endmodule

bind flash_pe_seq fseq_checker u_fseq_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .done      (done),
  .err       (err),
  .spi_cs_n  (spi_cs_n),
  .spi_sclk  (spi_sclk),
  .rd_req    (rd_req)
);

// File: tb/flash_pe_seq_test.sv
module flash_pe_seq_test;
  localparam int HALF = 2;
  localparam int PLIM = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, req_valid, req_ready, rd_req, spi_sclk, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;
  logic        done, err;
  logic [1:0]  req_op;
  logic [15:0] req_addr, req_len, rd_addr;
  logic [7:0]  rd_data = 8'h00;

  flash_pe_seq #(.CLK_HALF(HALF), .POLL_LIMIT(PLIM)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_len(req_len),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .done(done), .err(err)
  );

  int checks = 0;
  int errors = 0;
  logic [8:0] exp_q[$];
  localparam logic [8:0] END_MARK = 9'h100;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  always @(posedge clk) if (rd_req) rd_data <= pat(rd_addr);

  // Flash model and monitor
  bit         frame_open = 0, seen_frame = 0, wel = 0, wel_stuck = 0;
  int         bitcnt = 0, busy_left = 0, busy_set = 0, gap_cnt = 0;
  logic [7:0] sh_in = 8'h00, first_b = 8'h00, stat = 8'h00;
  logic [8:0] got_b, got_m;

  always @(negedge clk) if (spi_cs_n === 1'b1) gap_cnt++;

  always @(negedge spi_cs_n) begin
    chk(spi_sclk == 1'b0, "R2 sclk low at select", spi_sclk, 0);
    if (seen_frame) chk(gap_cnt >= 2*HALF, "R9 deselect gap", gap_cnt, 2*HALF);
    seen_frame = 1; frame_open = 1; bitcnt = 0; first_b = 8'h00;
  end

  always @(posedge spi_sclk) if (frame_open) begin
    sh_in = {sh_in[6:0], spi_mosi};
    bitcnt++;
    if (bitcnt % 8 == 0) begin
      if (bitcnt == 8) first_b = sh_in;
      if (exp_q.size() == 0) chk(0, "R3 R4 R6 R7 unexpected byte", sh_in, 0);
      else begin
        got_b = exp_q.pop_front();
        chk(got_b == {1'b0, sh_in}, "R3 R4 R6 R7 frame byte", sh_in, got_b);
      end
    end
  end

  always @(negedge spi_sclk) if (frame_open && first_b == 8'h05 && bitcnt >= 8) begin
    if (bitcnt % 8 == 0) begin
      stat = {6'b0, wel, busy_left != 0};
      if (busy_left > 0) busy_left--;
    end
    spi_miso = stat[7 - (bitcnt % 8)];
  end

  always @(posedge spi_cs_n) if (frame_open) begin
    frame_open = 0;
    gap_cnt = 0;
    chk(spi_sclk == 1'b0, "R2 sclk low at deselect", spi_sclk, 0);
    chk(bitcnt % 8 == 0, "R9 whole bytes", bitcnt % 8, 0);
    if (exp_q.size() == 0) chk(0, "R5 unexpected frame end", 0, END_MARK);
    else begin
      got_m = exp_q.pop_front();
      chk(got_m == END_MARK, "R5 frame end position", got_m, END_MARK);
    end
    if (bitcnt >= 8) begin
      if (first_b == 8'h06 && !wel_stuck) wel = 1;
      if (first_b == 8'h02 || first_b == 8'hD8 || first_b == 8'hC7) begin
        wel = 0;
        busy_left = busy_set;
      end
    end
  end

  task automatic push_b(input logic [7:0] b);
    exp_q.push_back({1'b0, b});
  endtask

  task automatic push_poll(input int busy, input bit tmo);
    push_b(8'h05);
    for (int i = 0; i < (tmo ? PLIM : busy + 1); i++) push_b(8'h00);
    exp_q.push_back(END_MARK);
  endtask

  task automatic push_pre();
    push_b(8'h06); exp_q.push_back(END_MARK);
    push_b(8'h05); push_b(8'h00); exp_q.push_back(END_MARK);
  endtask

  // Driver: queues expected frames, issues the request, checks completion
  task automatic run_req(input logic [1:0] op, input logic [15:0] addr, input int nbytes,
                         input int busy, input bit wel_ok, input bit tmo);
    int a, rem, ch;
    bit exp_err;
    exp_err = !wel_ok || tmo;
    if (op == 2'b00) begin
      a = addr; rem = nbytes;
      while (rem > 0) begin
        ch = 256 - (a % 256);
        if (rem < ch) ch = rem;
        push_pre();
        if (!wel_ok) break;
        push_b(8'h02); push_b(8'h00); push_b(8'((a >> 8) & 255)); push_b(8'(a & 255));
        for (int i = 0; i < ch; i++) push_b(pat(16'(a + i)));
        exp_q.push_back(END_MARK);
        push_poll(busy, tmo);
        if (tmo) break;
        a = (a + ch) & 16'hFFFF;
        rem -= ch;
      end
    end else begin
      push_pre();
      if (wel_ok) begin
        if (op == 2'b01) begin
          push_b(8'hD8); push_b(8'h00); push_b(addr[15:8]); push_b(addr[7:0]);
        end else push_b(8'hC7);
        exp_q.push_back(END_MARK);
        push_poll(busy, tmo);
      end
    end
    busy_set = busy;
    wel_stuck = !wel_ok;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready when idle", req_ready, 1);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_len = 16'(nbytes - 1);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b0, "R1 ready low while busy", req_ready, 0);
    while (!done) @(negedge clk);
    chk(err == exp_err, "R3 R8 R10 error flag", err, exp_err);
    chk(exp_q.size() == 0, "R5 all frames issued", exp_q.size(), 0);
    @(negedge clk);
    chk(done == 1'b0, "R10 done single pulse", done, 0);
    chk(err == 1'b0, "R10 err only with done", err, 0);
    exp_q.delete();
  endtask

  bit finished = 0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'b00; req_addr = '0; req_len = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(spi_cs_n == 1'b1, "R11 reset cs_n", spi_cs_n, 1);
    chk(spi_sclk == 1'b0, "R11 reset sclk", spi_sclk, 0);
    chk(req_ready == 1'b1, "R11 reset ready", req_ready, 1);
    chk(done == 1'b0 && err == 1'b0, "R11 reset done/err", {done, err}, 0);

    run_req(2'b00, 16'h0010, 4, 2, 1, 0);    // R4 R7 short program
    run_req(2'b00, 16'h01FE, 5, 1, 1, 0);    // R5 crossing split 2+3
    run_req(2'b01, 16'h8123, 1, 3, 1, 0);    // R6 sector erase
    run_req(2'b10, 16'h1234, 1, 0, 1, 0);    // R6 bulk erase, address ignored
    run_req(2'b11, 16'h5555, 1, 2, 1, 0);    // R6 code 11 acts as bulk
    run_req(2'b00, 16'h0040, 3, 2, 0, 0);    // R3 latch not set
    run_req(2'b00, 16'h0300, 256, 2, 1, 0);  // R5 full page, one piece
    run_req(2'b01, 16'h0001, 1, 50, 1, 1);   // R8 poll timeout
    run_req(2'b00, 16'h0FFF, 2, PLIM-1, 1, 0); // R7 R8 last read before timeout, R5 split

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule